// File: doc/BRIEF.md
# Device-Side Address Translation Cache

This block sits inside an I/O device and keeps a small store of recent page translations. Device logic sends it DMA requests that carry a function number and an untranslated address. When the page is cached as a translation, the block returns the translated address with the translated flag set. When the page is cached as "no translation", the block returns the original address with the flag clear. In both cases the answer comes one cycle later, and the host is not asked.

When a lookup misses, the block sends one translation request to the host, carrying the function and the page number. It then stops taking new DMA requests until a completion comes back. A successful completion installs a normal entry and answers the waiting request with the translated address. A failed completion installs a negative entry and answers with the untranslated address. Entries are keyed on the function number together with the 4 KiB page number. Slots are refilled in round-robin order. An invalidate port removes one function/page pair, or every entry at once.

Top module: `atc_cache`

## Requirements
- R1: After reset the cache is empty, `req_ready` is 1, and `rsp_valid` and `xreq_valid` are 0. The first request to any page misses.
- R2: A request that misses is answered by a single-cycle `xreq_valid` pulse in the cycle after acceptance. The pulse carries the request's function on `xreq_func` and address bits [ADDR_W-1:12] on `xreq_vpn`.
- R3: While a miss is pending, a completion with `xcpl_ok`=1 produces `rsp_valid` in the next cycle. `rsp_addr` is {`xcpl_ppn`, original bits [11:0]} and `rsp_translated` is 1. The translation is then cached.
- R4: A request that hits a cached translation gets `rsp_valid` in the cycle after acceptance, with the translated address and `rsp_translated`=1. No `xreq_valid` is raised.
- R5: A completion with `xcpl_ok`=0 answers with the original address and `rsp_translated`=0, and caches a negative entry. A later request to that function/page is answered untranslated in the next cycle, with no new `xreq_valid`.
- R6: The lookup key includes the function number. The same page under a different function misses.
- R7: While a miss is pending, `req_ready` is 0 and other requests stall. A completion that arrives while no miss is pending is ignored.
- R8: An `inv_valid` cycle with `inv_all`=0 removes only the entry matching both `inv_func` and `inv_vpn`. Other entries keep hitting.
- R9: An `inv_valid` cycle with `inv_all`=1 removes every entry.
- R10: Installs fill slots in round-robin order. Once all ENTRIES slots are used, the next install replaces the oldest slot and leaves the others intact.
- R11: `req_ready` is 0 in any cycle where `inv_valid` is 1, so a request presented then is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_func | input | FUNC_W | Requesting function number |
| req_addr | input | ADDR_W | Untranslated address |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | ADDR_W | Outgoing DMA address |
| rsp_translated | output | 1 | 1 when rsp_addr is translated |
| xreq_valid | output | 1 | Translation request pulse to host |
| xreq_func | output | FUNC_W | Function of the translation request |
| xreq_vpn | output | ADDR_W-PAGE_SHIFT | Page number to translate |
| xcpl_valid | input | 1 | Translation completion present |
| xcpl_ok | input | 1 | Completion reports a translation exists |
| xcpl_ppn | input | ADDR_W-PAGE_SHIFT | Translated page number |
| inv_valid | input | 1 | Invalidate strobe |
| inv_all | input | 1 | Invalidate every entry |
| inv_func | input | FUNC_W | Function to invalidate |
| inv_vpn | input | ADDR_W-PAGE_SHIFT | Page to invalidate |

## Verification
The bench builds the block with ENTRIES=4, ADDR_W=20, FUNC_W=2 and PAGE_SHIFT=12. With four slots, a short sequence of installs fills the cache and wraps the round-robin pointer, so eviction of the oldest entry is observable, while the other entries stay resident. The 8-bit page number and 2-bit function keep the expected addresses easy to write down. Functions 0 through 3 are all used, so function-keyed misses and targeted invalidates can be told apart from page matches.

// File: rtl/atc_pkg.sv
package atc_pkg;
  typedef enum logic {
    MC_IDLE = 1'b0,
    MC_WAIT = 1'b1
  } miss_state_e;
endpackage

// File: rtl/atc_rr_ptr.sv
module atc_rr_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [IDX_W-1:0] slot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (advance) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign slot = ptr_q;
endmodule

// File: rtl/atc_tag_store.sv
module atc_tag_store #(
  parameter int ENTRIES = 8,
  parameter int FUNC_W  = 3,
  parameter int VPN_W   = 20,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FUNC_W-1:0] lk_func,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic              lk_neg,
  output logic [VPN_W-1:0]  lk_ppn,
  input  logic              ins_en,
  input  logic [IDX_W-1:0]  ins_slot,
  input  logic [FUNC_W-1:0] ins_func,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic              ins_neg,
  input  logic [VPN_W-1:0]  ins_ppn,
  input  logic              inv_en,
  input  logic              inv_all,
  input  logic [FUNC_W-1:0] inv_func,
  input  logic [VPN_W-1:0]  inv_vpn
);
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] neg_vec;
  logic [VPN_W-1:0]   ppn_mem [ENTRIES];

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic              v_q;
      logic              n_q;
      logic [FUNC_W-1:0] f_q;
      logic [VPN_W-1:0]  p_q;
      logic              kill;
      logic              load;

      assign load = ins_en && (ins_slot == IDX_W'(i));
      assign kill = inv_en && v_q &&
                    (inv_all || ((f_q == inv_func) && (p_q == inv_vpn)));

      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          n_q <= 1'b0;
          f_q <= '0;
          p_q <= '0;
        end else if (load) begin
          v_q <= 1'b1;
          n_q <= ins_neg;
          f_q <= ins_func;
          p_q <= ins_vpn;
        end else if (kill) begin
          v_q <= 1'b0;
        end
      end

      assign hit_vec[i] = v_q && (f_q == lk_func) && (p_q == lk_vpn);
      assign neg_vec[i] = n_q;
    end
  endgenerate

  // Payload array: single write port, no reset, suited to RAM inference.
  always_ff @(posedge clk) begin
    if (ins_en) begin
      ppn_mem[ins_slot] <= ins_ppn;
    end
  end

  always_comb begin
    lk_ppn = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (hit_vec[k]) begin
        lk_ppn = lk_ppn | ppn_mem[k];
      end
    end
  end

  assign lk_hit = |hit_vec;
  assign lk_neg = |(hit_vec & neg_vec);
endmodule

// File: rtl/atc_miss_ctrl.sv
module atc_miss_ctrl
  import atc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FUNC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FUNC_W-1:0] start_func,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              cpl_valid,
  output logic              pend,
  output logic              take,
  output logic              xreq_pulse,
  output logic [FUNC_W-1:0] pend_func,
  output logic [ADDR_W-1:0] pend_addr
);
  miss_state_e state_q;
  logic        xreq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= MC_IDLE;
      xreq_q    <= 1'b0;
      pend_func <= '0;
      pend_addr <= '0;
    end else begin
      xreq_q <= 1'b0;
      case (state_q)
        MC_IDLE: if (start) begin
          state_q   <= MC_WAIT;
          xreq_q    <= 1'b1;
          pend_func <= start_func;
          pend_addr <= start_addr;
        end
        MC_WAIT: if (cpl_valid) begin
          state_q <= MC_IDLE;
        end
        default: state_q <= MC_IDLE;
      endcase
    end
  end

  assign pend       = (state_q == MC_WAIT);
  assign take       = pend && cpl_valid;
  assign xreq_pulse = xreq_q;
endmodule

// File: rtl/atc_cache.sv
module atc_cache #(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 32,
  parameter int FUNC_W     = 3,
  parameter int PAGE_SHIFT = 12,
  localparam int VPN_W = ADDR_W - PAGE_SHIFT,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_translated,
  output logic              xreq_valid,
  output logic [FUNC_W-1:0] xreq_func,
  output logic [VPN_W-1:0]  xreq_vpn,
  input  logic              xcpl_valid,
  input  logic              xcpl_ok,
  input  logic [VPN_W-1:0]  xcpl_ppn,
  input  logic              inv_valid,
  input  logic              inv_all,
  input  logic [FUNC_W-1:0] inv_func,
  input  logic [VPN_W-1:0]  inv_vpn
);
  logic              pend_q;
  logic              cpl_take;
  logic [FUNC_W-1:0] pend_func;
  logic [ADDR_W-1:0] pend_addr;
  logic              lk_hit;
  logic              lk_neg;
  logic [VPN_W-1:0]  lk_ppn;
  logic [IDX_W-1:0]  victim;
  logic              accept;
  logic              accept_miss;
  logic [VPN_W-1:0]  req_vpn;

  assign req_vpn     = req_addr[ADDR_W-1:PAGE_SHIFT];
  assign req_ready   = !pend_q && !inv_valid;
  assign accept      = req_valid && req_ready;
  assign accept_miss = accept && !lk_hit;

  atc_tag_store #(
    .ENTRIES(ENTRIES),
    .FUNC_W (FUNC_W),
    .VPN_W  (VPN_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .lk_func (req_func),
    .lk_vpn  (req_vpn),
    .lk_hit  (lk_hit),
    .lk_neg  (lk_neg),
    .lk_ppn  (lk_ppn),
    .ins_en  (cpl_take),
    .ins_slot(victim),
    .ins_func(pend_func),
    .ins_vpn (pend_addr[ADDR_W-1:PAGE_SHIFT]),
    .ins_neg (!xcpl_ok),
    .ins_ppn (xcpl_ok ? xcpl_ppn : '0),
    .inv_en  (inv_valid),
    .inv_all (inv_all),
    .inv_func(inv_func),
    .inv_vpn (inv_vpn)
  );

  atc_rr_ptr #(
    .ENTRIES(ENTRIES)
  ) u_rr (
    .clk    (clk),
    .rst    (rst),
    .advance(cpl_take),
    .slot   (victim)
  );

  atc_miss_ctrl #(
    .ADDR_W(ADDR_W),
    .FUNC_W(FUNC_W)
  ) u_miss (
    .clk       (clk),
    .rst       (rst),
    .start     (accept_miss),
    .start_func(req_func),
    .start_addr(req_addr),
    .cpl_valid (xcpl_valid),
    .pend      (pend_q),
    .take      (cpl_take),
    .xreq_pulse(xreq_valid),
    .pend_func (pend_func),
    .pend_addr (pend_addr)
  );

  assign xreq_func = pend_func;
  assign xreq_vpn  = pend_addr[ADDR_W-1:PAGE_SHIFT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_addr       <= '0;
      rsp_translated <= 1'b0;
    end else if (cpl_take) begin
      rsp_valid      <= 1'b1;
      rsp_translated <= xcpl_ok;
      rsp_addr       <= xcpl_ok ? {xcpl_ppn, pend_addr[PAGE_SHIFT-1:0]} : pend_addr;
    end else if (accept && lk_hit) begin
      rsp_valid      <= 1'b1;
      rsp_translated <= !lk_neg;
      rsp_addr       <= lk_neg ? req_addr : {lk_ppn, req_addr[PAGE_SHIFT-1:0]};
    end else begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/atc_cache_checker.sv
module atc_cache_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic inv_valid,
  input logic xreq_valid,
  input logic xcpl_valid,
  input logic xcpl_ok,
  input logic rsp_valid,
  input logic rsp_translated,
  input logic pend_q
);
  p_xreq_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    xreq_valid |=> !xreq_valid);

  p_xreq_stall_r7: assert property (@(posedge clk) disable iff (rst)
    xreq_valid |-> !req_ready);

  p_accept_result_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rsp_valid ^ xreq_valid));

  p_cpl_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    (pend_q && xcpl_valid) |=> (rsp_valid && (rsp_translated == $past(xcpl_ok))));

  p_idle_cpl_r7: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && xcpl_valid && !(req_valid && req_ready)) |=> !rsp_valid);

  p_inv_block_r11: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !req_ready);
endmodule

bind atc_cache atc_cache_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .inv_valid     (inv_valid),
  .xreq_valid    (xreq_valid),
  .xcpl_valid    (xcpl_valid),
  .xcpl_ok       (xcpl_ok),
  .rsp_valid     (rsp_valid),
  .rsp_translated(rsp_translated),
  .pend_q        (pend_q)
);

// File: tb/atc_cache_bench.sv
`timescale 1ns/1ps
module atc_cache_bench;
  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 20;
  localparam int FUNC_W  = 2;
  localparam int PSHIFT  = 12;
  localparam int VPN_W   = ADDR_W - PSHIFT;
  localparam int NVEC    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [FUNC_W-1:0] req_func = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic rsp_valid;
  logic [ADDR_W-1:0] rsp_addr;
  logic rsp_translated;
  logic xreq_valid;
  logic [FUNC_W-1:0] xreq_func;
  logic [VPN_W-1:0] xreq_vpn;
  logic xcpl_valid = 1'b0;
  logic xcpl_ok = 1'b0;
  logic [VPN_W-1:0] xcpl_ppn = '0;
  logic inv_valid = 1'b0;
  logic inv_all = 1'b0;
  logic [FUNC_W-1:0] inv_func = '0;
  logic [VPN_W-1:0] inv_vpn = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  atc_cache #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .FUNC_W(FUNC_W), .PAGE_SHIFT(PSHIFT)
  ) u_atc_cache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_func(req_func), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_translated(rsp_translated),
    .xreq_valid(xreq_valid), .xreq_func(xreq_func), .xreq_vpn(xreq_vpn),
    .xcpl_valid(xcpl_valid), .xcpl_ok(xcpl_ok), .xcpl_ppn(xcpl_ppn),
    .inv_valid(inv_valid), .inv_all(inv_all), .inv_func(inv_func), .inv_vpn(inv_vpn)
  );

  // {func[1:0], addr[19:0], miss, ok, ppn[7:0], exp_tr, exp_addr[19:0]}
  localparam logic [52:0] VEC [NVEC] = '{
    {2'd1, 20'h05123, 1'b1, 1'b1, 8'hA0, 1'b1, 20'hA0123},  // R1 empty, R2, R3
    {2'd1, 20'h05FFF, 1'b0, 1'b0, 8'h00, 1'b1, 20'hA0FFF},  // R4 hit
    {2'd2, 20'h05010, 1'b1, 1'b1, 8'hB1, 1'b1, 20'hB1010},  // R6 other function
    {2'd1, 20'h07444, 1'b1, 1'b0, 8'h00, 1'b0, 20'h07444},  // R5 failure
    {2'd1, 20'h07888, 1'b0, 1'b0, 8'h00, 1'b0, 20'h07888},  // R5 negative hit
    {2'd2, 20'h05ABC, 1'b0, 1'b0, 8'h00, 1'b1, 20'hB1ABC},  // R4/R6
    {2'd0, 20'h00000, 1'b1, 1'b1, 8'hC2, 1'b1, 20'hC2000},  // fills slot 3
    {2'd3, 20'h0FF01, 1'b1, 1'b1, 8'hD3, 1'b1, 20'hD3F01},  // R10 evicts slot 0
    {2'd1, 20'h05123, 1'b1, 1'b1, 8'hE4, 1'b1, 20'hE4123},  // R10 evicted page misses
    {2'd0, 20'h00777, 1'b0, 1'b0, 8'h00, 1'b1, 20'hC2777}   // R10 survivor hits
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] f, input logic [19:0] a, input logic miss,
                        input logic ok, input logic [7:0] ppn, input logic etr,
                        input logic [19:0] eaddr, input string tag);
    @(negedge clk);
    chk({tag, " R7 ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_func = f; req_addr = a;
    @(negedge clk);
    if (miss) begin
      chk({tag, " R2 xreq pulse"}, 32'(xreq_valid), 32'd1);
      chk({tag, " R2 xreq func"}, 32'(xreq_func), 32'(f));
      chk({tag, " R2 xreq page"}, 32'(xreq_vpn), 32'(a[19:12]));
      chk({tag, " R7 stall"}, 32'(req_ready), 32'd0);
      req_addr = a ^ 20'h10000;           // R7: another request held while pending
      @(negedge clk);
      chk({tag, " R2 pulse ends"}, 32'(xreq_valid), 32'd0);
      chk({tag, " R7 still stalled"}, 32'(req_ready), 32'd0);
      xcpl_valid = 1'b1; xcpl_ok = ok; xcpl_ppn = ppn;
      @(negedge clk);
      xcpl_valid = 1'b0;
      req_valid = 1'b0;
    end else begin
      req_valid = 1'b0;
      chk({tag, " R4 no xreq on hit"}, 32'(xreq_valid), 32'd0);
    end
    chk({tag, " response valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " response address"}, 32'(rsp_addr), 32'(eaddr));
    chk({tag, " translated flag"}, 32'(rsp_translated), 32'(etr));
    @(negedge clk);
    chk({tag, " R7 no extra activity"}, 32'({rsp_valid, xreq_valid}), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected less", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1 xreq_valid after reset", 32'(xreq_valid), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      logic [52:0] e;
      string t;
      e = VEC[v];
      t = $sformatf("vec%0d", v);
      access(e[52:51], e[50:31], e[30], e[29], e[28:21], e[20], e[19:0], t);
    end

    // R11: request alongside an invalidate is not accepted
    @(negedge clk);
    inv_valid = 1'b1; inv_all = 1'b0; inv_func = 2'd3; inv_vpn = 8'h77;
    req_valid = 1'b1; req_func = 2'd0; req_addr = 20'h00777;
    #1;
    chk("R11 ready low during invalidate", 32'(req_ready), 32'd0);
    @(negedge clk);
    inv_valid = 1'b0; req_valid = 1'b0;
    chk("R11 no response", 32'({rsp_valid, xreq_valid}), 32'd0);

    // R7: completion with nothing pending is ignored
    @(negedge clk);
    xcpl_valid = 1'b1; xcpl_ok = 1'b1; xcpl_ppn = 8'h99;
    @(negedge clk);
    xcpl_valid = 1'b0;
    chk("R7 idle completion ignored", 32'({rsp_valid, xreq_valid, req_ready}), 32'd1);

    // R8: targeted invalidate of function 0 page 0x00
    @(negedge clk);
    inv_valid = 1'b1; inv_all = 1'b0; inv_func = 2'd0; inv_vpn = 8'h00;
    @(negedge clk);
    inv_valid = 1'b0;
    access(2'd3, 20'h0FF00, 1'b0, 1'b0, 8'h00, 1'b1, 20'hD3F00, "R8 other entry kept");
    access(2'd0, 20'h00001, 1'b1, 1'b1, 8'h55, 1'b1, 20'h55001, "R8 target removed");

    // R9: invalidate all
    @(negedge clk);
    inv_valid = 1'b1; inv_all = 1'b1;
    @(negedge clk);
    inv_valid = 1'b0; inv_all = 1'b0;
    access(2'd1, 20'h05123, 1'b1, 1'b1, 8'h66, 1'b1, 20'h66123, "R9 all removed");
    access(2'd0, 20'h00002, 1'b1, 1'b0, 8'h00, 1'b0, 20'h00002, "R9 all removed fn0");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule